// File: doc/BRIEF.md
# Dual-store memory access sequencer

This block schedules the memory writes of an instruction that carries one or two parallel stores. It runs on a single clock. A phase flag splits every CPU cycle into two halves: the H3 half comes first and the H1 half second. Each destination address is compared against a configurable internal address window. An address inside the window is written through a registered internal write strobe port. An address outside the window goes to an external bus write port. That port latches its address and data and keeps its write strobe high for a fixed number of bus beats.

The internal/external mix of the two destinations decides the order of the writes. Two internal destinations both finish in one CPU cycle. An external first destination with an internal second one also finishes in one cycle. An internal first destination with an external second one needs an extra CPU cycle on the bus, and so do two external destinations. For these two mixes the block raises a pipeline hold, and while hold is high it refuses any new store pair. Instruction fetch, operand reads and execution stay upstream.

Top module: `dual_store_seq`

## Requirements
- R1: A store pair is accepted only at a clock edge that ends an H1 half, while hold is low, `st_valid` is 1 and `st_class` equals 2'b11. Any other class value causes no internal or external write.
- R2: A destination address A is internal when INT_BASE <= A <= INT_LAST (defaults 8'h10 and 8'h8F). Every other address is external.
- R3: With `st_dual` = 0, only the first destination is written. The write happens in the H3 half that follows acceptance: an internal strobe for one clock, or the start of an external bus write.
- R4: When both destinations are internal, the first is written through `iw_en`/`iw_addr`/`iw_data` in H3 and the second in the following H1 half of the same CPU cycle.
- R5: When the first destination is external and the second is internal, the bus write of the first runs over H3 and H1 while the second is written internally in that H1. Hold stays low.
- R6: When the first destination is internal and the second is external, the first is written internally in H3. In the same cycle's H1 the external port shows the second address and data with `xw_en` low. The bus write of the second then runs over H3 and H1 of the next CPU cycle.
- R7: When both destinations are external, the first bus write occupies H3 and H1 of the execute cycle. The second bus write follows in H3 and H1 of the next CPU cycle.
- R8: In the cases of R6 and R7, hold is high from the execute cycle's H1 half through the next cycle's H3 half, which is two clocks. A store pair presented at the edge between these two clocks is ignored. Hold is never high in any other case.
- R9: `phase_h1` is 1 during H1 halves and 0 during H3 halves. It alternates on every clock after reset and is 1 while reset is held.
- R10: Each external store keeps `xw_en` high for exactly two clocks, with `xw_addr` and `xw_data` unchanged over those two clocks.
- R11: While reset is high and after its release, `iw_en`, `xw_en` and `hold` are 0 until a pair is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one half-phase |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A store pair is presented |
| st_class | input | 2 | Instruction class tag (top two opcode bits) |
| st_dual | input | 1 | 1 = two stores, 0 = first destination only |
| st_addr1 | input | AW | First destination address |
| st_data1 | input | DW | First destination data |
| st_addr2 | input | AW | Second destination address |
| st_data2 | input | DW | Second destination data |
| phase_h1 | output | 1 | 1 during the H1 half, 0 during H3 |
| hold | output | 1 | Pipeline hold for the extra bus cycle |
| iw_en | output | 1 | Internal RAM write strobe |
| iw_addr | output | AW | Internal RAM write address |
| iw_data | output | DW | Internal RAM write data |
| xw_en | output | 1 | External bus write active |
| xw_addr | output | AW | External bus write address |
| xw_data | output | DW | External bus write data |

## Verification
A wrong address-window decision or a wrong job flag shows up in the H3 half right after acceptance, as a strobe on the wrong port. A stale second-destination flag shows up one half later, as a missing or misplaced H1 strobe or a wrong hold. A bad step counter or bus-beat counter shows up at the latest in the second CPU cycle: hold stays high, the bus write gets shorter or longer, or the store pair offered under hold is accepted. Each of these is visible at the ports within four clocks of acceptance.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // Class tag of instructions that carry parallel stores
  localparam logic [1:0] CLASS_PSTORE = 2'b11;

  // Position of a job inside its execute cycle and the optional extra cycle
  typedef enum logic [1:0] {
    STP_C0_H3 = 2'd0,
    STP_C0_H1 = 2'd1,
    STP_C1_H3 = 2'd2,
    STP_C1_H1 = 2'd3
  } step_e;

endpackage

// File: rtl/dss_range_decode.sv
module dss_range_decode #(
  parameter int unsigned     AW       = 8,
  parameter logic [AW-1:0]   INT_BASE = 8'h10,
  parameter logic [AW-1:0]   INT_LAST = 8'h8F
) (
  input  logic [AW-1:0] addr,
  output logic          is_int
);

  assign is_int = (addr >= INT_BASE) && (addr <= INT_LAST);

endmodule

// File: rtl/dss_ext_port.sv
module dss_ext_port #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned BEATS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          go,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic          wr,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  localparam int unsigned   CW      = $clog2(BEATS + 1);
  localparam logic [CW-1:0] BEATS_C = CW'(BEATS);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      wr    <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else begin
      if (ld) begin
        addr <= ld_addr;
        data <= ld_data;
      end
      if (go) begin
        cnt_q <= BEATS_C;
        wr    <= 1'b1;
      end else begin
        if (cnt_q != '0) cnt_q <= cnt_q - ONE_C;
        wr <= (cnt_q > ONE_C);
      end
    end
  end

  // R10: a new bus write starts only when the previous one ends this clock
  p_go_free_r10: assert property (@(posedge clk) disable iff (rst)
    go |-> (cnt_q <= ONE_C));

  // R10: a running bus write keeps its address and data
  p_bus_steady_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && !ld) |=> ($stable(addr) && $stable(data)));

  p_go_drives_r10: assert property (@(posedge clk) disable iff (rst)
    go |=> wr);

endmodule

// File: rtl/dss_sched.sv
module dss_sched
  import dss_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph_h1,
  input  logic          acc,
  input  logic          in_dual,
  input  logic          in_int1,
  input  logic          in_int2,
  input  logic [AW-1:0] in_a1,
  input  logic [DW-1:0] in_d1,
  input  logic [AW-1:0] in_a2,
  input  logic [DW-1:0] in_d2,
  output logic          hold,
  output logic          iw_en,
  output logic [AW-1:0] iw_addr,
  output logic [DW-1:0] iw_data,
  output logic          p_ld,
  output logic          p_go,
  output logic [AW-1:0] p_addr,
  output logic [DW-1:0] p_data
);

  logic          act_q;
  step_e         stp_q;
  logic          j_dual, j_int1, j_int2;
  logic [AW-1:0] j_a1, j_a2;
  logic [DW-1:0] j_d1, j_d2;
  logic          j_extra;

  assign j_extra = j_dual && !j_int2;

  // Port requests, registered inside the external port
  always_comb begin
    p_ld   = 1'b0;
    p_go   = 1'b0;
    p_addr = j_a2;
    p_data = j_d2;
    if (acc) begin
      p_addr = in_a1;
      p_data = in_d1;
      if (!in_int1) begin
        p_ld = 1'b1;
        p_go = 1'b1;
      end
    end else if (act_q) begin
      case (stp_q)
        STP_C0_H3: if (j_extra && j_int1) p_ld = 1'b1;
        STP_C0_H1: if (j_extra) begin
          p_ld = 1'b1;
          p_go = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      stp_q   <= STP_C0_H3;
      hold    <= 1'b0;
      iw_en   <= 1'b0;
      iw_addr <= '0;
      iw_data <= '0;
      j_dual  <= 1'b0;
      j_int1  <= 1'b0;
      j_int2  <= 1'b0;
      j_a1    <= '0;
      j_a2    <= '0;
      j_d1    <= '0;
      j_d2    <= '0;
    end else begin
      iw_en <= 1'b0;
      if (acc) begin
        act_q   <= 1'b1;
        stp_q   <= STP_C0_H3;
        j_dual  <= in_dual;
        j_int1  <= in_int1;
        j_int2  <= in_int2;
        j_a1    <= in_a1;
        j_a2    <= in_a2;
        j_d1    <= in_d1;
        j_d2    <= in_d2;
        iw_en   <= in_int1;
        iw_addr <= in_a1;
        iw_data <= in_d1;
      end else if (act_q) begin
        case (stp_q)
          STP_C0_H3: begin
            stp_q <= STP_C0_H1;
            hold  <= j_extra;
            if (j_dual && j_int2) begin
              iw_en   <= 1'b1;
              iw_addr <= j_a2;
              iw_data <= j_d2;
            end
          end
          STP_C0_H1: begin
            if (j_extra) stp_q <= STP_C1_H3;
            else         act_q <= 1'b0;
          end
          STP_C1_H3: begin
            stp_q <= STP_C1_H1;
            hold  <= 1'b0;
          end
          default: act_q <= 1'b0;
        endcase
      end
    end
  end

  // R8: hold rises only at the start of an H1 half
  p_hold_in_h1_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> ph_h1);

  // R8: hold lasts exactly two clocks
  p_hold_two_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |=> hold ##1 !hold);

  // R4: an internal write in H1 always carries the second destination
  p_h1_write_dst2_r4: assert property (@(posedge clk) disable iff (rst)
    (iw_en && ph_h1) |-> (iw_addr == j_a2));

endmodule

// File: rtl/dual_store_seq.sv
module dual_store_seq
  import dss_pkg::*;
#(
  parameter int unsigned   AW       = 8,
  parameter int unsigned   DW       = 16,
  parameter logic [AW-1:0] INT_BASE = 8'h10,
  parameter logic [AW-1:0] INT_LAST = 8'h8F,
  parameter int unsigned   BEATS    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [1:0]    st_class,
  input  logic          st_dual,
  input  logic [AW-1:0] st_addr1,
  input  logic [DW-1:0] st_data1,
  input  logic [AW-1:0] st_addr2,
  input  logic [DW-1:0] st_data2,
  output logic          phase_h1,
  output logic          hold,
  output logic          iw_en,
  output logic [AW-1:0] iw_addr,
  output logic [DW-1:0] iw_data,
  output logic          xw_en,
  output logic [AW-1:0] xw_addr,
  output logic [DW-1:0] xw_data
);

  localparam int unsigned NDST = 2;

  logic [AW-1:0] dst_a   [NDST];
  logic          dst_int [NDST];
  logic          acc;
  logic          p_ld, p_go;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  assign dst_a[0] = st_addr1;
  assign dst_a[1] = st_addr2;

  for (genvar g = 0; g < NDST; g++) begin : g_dec
    dss_range_decode #(
      .AW(AW), .INT_BASE(INT_BASE), .INT_LAST(INT_LAST)
    ) u_dec (
      .addr   (dst_a[g]),
      .is_int (dst_int[g])
    );
  end

  // Half-phase flag: H1 while reset, then alternating
  always_ff @(posedge clk) begin
    if (rst) phase_h1 <= 1'b1;
    else     phase_h1 <= !phase_h1;
  end

  assign acc = st_valid && (st_class == CLASS_PSTORE) && phase_h1 && !hold;

  dss_sched #(.AW(AW), .DW(DW)) u_sched (
    .clk     (clk),
    .rst     (rst),
    .ph_h1   (phase_h1),
    .acc     (acc),
    .in_dual (st_dual),
    .in_int1 (dst_int[0]),
    .in_int2 (dst_int[1]),
    .in_a1   (st_addr1),
    .in_d1   (st_data1),
    .in_a2   (st_addr2),
    .in_d2   (st_data2),
    .hold    (hold),
    .iw_en   (iw_en),
    .iw_addr (iw_addr),
    .iw_data (iw_data),
    .p_ld    (p_ld),
    .p_go    (p_go),
    .p_addr  (p_addr),
    .p_data  (p_data)
  );

  dss_ext_port #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_port (
    .clk     (clk),
    .rst     (rst),
    .ld      (p_ld),
    .go      (p_go),
    .ld_addr (p_addr),
    .ld_data (p_data),
    .wr      (xw_en),
    .addr    (xw_addr),
    .data    (xw_data)
  );

  // R9: the half-phase flag alternates every clock
  p_phase_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase_h1 != $past(phase_h1)));

  // R6: no internal write while the extra bus cycle is held
  p_hold_no_int_r6: assert property (@(posedge clk) disable iff (rst)
    hold |-> !iw_en);

  // R7: in the H3 half under hold the bus is carrying the second store
  p_hold_bus_r7: assert property (@(posedge clk) disable iff (rst)
    (hold && !phase_h1) |-> xw_en);

endmodule

// File: tb/dual_store_seq_bench.sv
module dual_store_seq_bench;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 16;
  localparam logic [AW-1:0] BASE = 8'h10;
  localparam logic [AW-1:0] LAST = 8'h8F;

  logic          clk = 1'b0;
  logic          rst;
  logic          st_valid;
  logic [1:0]    st_class;
  logic          st_dual;
  logic [AW-1:0] st_addr1, st_addr2;
  logic [DW-1:0] st_data1, st_data2;
  logic          phase_h1, hold, iw_en, xw_en;
  logic [AW-1:0] iw_addr, xw_addr;
  logic [DW-1:0] iw_data, xw_data;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = !clk;

  dual_store_seq #(.AW(AW), .DW(DW), .INT_BASE(BASE), .INT_LAST(LAST)) u_dual_store_seq (
    .clk, .rst, .st_valid, .st_class, .st_dual, .st_addr1, .st_data1,
    .st_addr2, .st_data2, .phase_h1, .hold, .iw_en, .iw_addr, .iw_data,
    .xw_en, .xw_addr, .xw_data
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic is_in(input logic [AW-1:0] a);
    return (a >= BASE) && (a <= LAST);
  endfunction

  function automatic logic [DW-1:0] dat1(input logic [AW-1:0] a);
    return {a, a ^ 8'h5A};
  endfunction

  function automatic logic [DW-1:0] dat2(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  // strobe vector: {phase_h1, hold, iw_en, xw_en}
  function automatic logic [31:0] strb();
    return {28'd0, phase_h1, hold, iw_en, xw_en};
  endfunction

  task automatic run_job(input logic [1:0] cls, input logic dual,
                         input logic [AW-1:0] a1, input logic [AW-1:0] a2);
    logic i1, i2, ex, on;
    on = (cls == 2'b11);
    i1 = is_in(a1);
    i2 = is_in(a2);
    ex = on && dual && !i2;
    while (!(phase_h1 && !hold)) @(negedge clk);
    st_valid = 1'b1; st_class = cls; st_dual = dual;
    st_addr1 = a1; st_data1 = dat1(a1);
    st_addr2 = a2; st_data2 = dat2(a2);
    @(negedge clk); // execute cycle, H3
    st_valid = 1'b0;
    chk("R3 H3 strobes", strb(), {28'd0, 1'b0, 1'b0, on && i1, on && !i1});
    if (on && i1)  chk("R4 H3 internal dst1", {iw_addr, iw_data}, {a1, dat1(a1)});
    if (on && !i1) chk("R5 H3 bus dst1", {xw_addr, xw_data}, {a1, dat1(a1)});
    @(negedge clk); // execute cycle, H1
    chk("R4 H1 strobes", strb(), {28'd0, 1'b1, ex, on && dual && i2, on && !i1});
    if (on && dual && i2) chk("R5 H1 internal dst2", {iw_addr, iw_data}, {a2, dat2(a2)});
    if (on && !i1) chk("R10 bus dst1 steady", {xw_addr, xw_data}, {a1, dat1(a1)});
    if (ex && i1) chk("R6 port loaded in H1", {xw_addr, xw_data}, {a2, dat2(a2)});
    if (ex) begin
      // R8: offered under hold, must be ignored
      st_valid = 1'b1; st_class = 2'b11; st_dual = 1'b1;
      st_addr1 = 8'h20; st_data1 = 16'hBEEF;
      st_addr2 = 8'h30; st_data2 = 16'hCAFE;
    end
    @(negedge clk); // next cycle, H3
    st_valid = 1'b0;
    chk("R8 C1 H3 strobes", strb(), {28'd0, 1'b0, ex, 1'b0, ex});
    if (ex) chk("R7 bus dst2", {xw_addr, xw_data}, {a2, dat2(a2)});
    @(negedge clk); // next cycle, H1
    chk("R10 C1 H1 strobes", strb(), {28'd0, 1'b1, 1'b0, 1'b0, ex});
    if (ex) chk("R10 bus dst2 steady", {xw_addr, xw_data}, {a2, dat2(a2)});
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] pts [6];
    pts[0] = 8'h0F; pts[1] = 8'h10; pts[2] = 8'h40;
    pts[3] = 8'h8F; pts[4] = 8'h90; pts[5] = 8'hFF;
    rst = 1'b1; st_valid = 1'b0; st_class = 2'b00; st_dual = 1'b0;
    st_addr1 = '0; st_addr2 = '0; st_data1 = '0; st_data2 = '0;
    repeat (3) @(negedge clk);
    chk("R11 in reset", strb(), {28'd0, 1'b1, 1'b0, 1'b0, 1'b0});
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after reset H3", strb(), {28'd0, 1'b0, 1'b0, 1'b0, 1'b0});
    @(negedge clk);
    chk("R11 idle H1", strb(), {28'd0, 1'b1, 1'b0, 1'b0, 1'b0});
    // R1: other classes produce no write
    for (int c = 0; c < 3; c++) begin
      run_job(c[1:0], 1'b1, 8'h20, 8'hA0);
      run_job(c[1:0], 1'b0, 8'hC0, 8'h20);
    end
    // R2..R10 sweep over boundary addresses, single and dual
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run_job(2'b11, d[0], pts[i], pts[j]);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule